// File: doc/BRIEF.md
# SPI Mode Fault Detector

This block supervises the select line of an SPI port that can act as master or as slave. It brings the slave-select and serial-clock pins into the local clock domain and follows the progress of each transfer with a bit counter. When the port's role and the select level disagree, it raises a mode-fault flag. A fault as master forces the port off, marks the transmit buffer empty and clears the bit counter. A fault as slave only raises the flag and leaves the port running.

Four control bits are written together through one write port: enable, master select, fault enable and error-interrupt enable. The flag is cleared by a write-one pulse, or by a control write that turns off the enable bit or the fault enable bit. The interrupt output is a level that follows the flag, gated by the interrupt enable. The transfer length is a parameter with a default of 8 bits. The data shifter and the baud generator are not part of this block.

Top module: `spi_modf_guard`

## Requirements
- R1: After reset the four control bits (`ctl_q[0]` enable, `ctl_q[1]` master, `ctl_q[2]` fault enable, `ctl_q[3]` interrupt enable) read 0. The flag, counter, `irq` and `miso_oe` read 0, and `tx_empty` reads 1.
- R2: When enabled as master with fault enable set, a low slave-select sets the flag. With fault enable clear, a low select has no effect.
- R3: A master fault clears the enable bit, sets `tx_empty` and clears `bit_cnt`. The master bit keeps its value.
- R4: `irq` is high exactly when the flag and the interrupt-enable bit are both set.
- R5: As slave with clock phase 0, a transfer starts when select falls. Raising select before the transfer ends sets the flag, even if no clock edge came.
- R6: As slave with clock phase 1, a transfer starts only on a leading clock edge (the clock leaving the `cpol` level) while select is low. Select followed by deselect with no clock edges leaves the flag clear.
- R7: The counter counts sampling edges: leading edges when `cpha`=0 and trailing edges when `cpha`=1. After 8 full clock pulses the transfer is over and `bit_cnt` reads 0. Deselecting a slave at that point raises no fault.
- R8: A slave fault leaves the enable bit set and `bit_cnt` unchanged.
- R9: While a slave's select is high, `miso_oe` is low and clock edges do not change `bit_cnt`.
- R10: As master, a clear pulse is ignored while select is low. Once select is high, a clear pulse clears the flag. As slave, a clear pulse clears the flag.
- R11: A control write with enable 0 or fault enable 0 clears the flag. A write with enable 0 also clears `bit_cnt`.
- R12: A `tx_wr` pulse clears `tx_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase (0: sample on leading edge, 1: sample on trailing edge) |
| ctl_we | input | 1 | Control write strobe |
| ctl_din | input | 4 | Control data: enable, master, fault enable, interrupt enable (bits 0..3) |
| sts_clr | input | 1 | Write-one pulse that clears the flag |
| tx_wr | input | 1 | Transmit buffer write; clears tx_empty |
| ss_n_in | input | 1 | Slave-select pin, asynchronous, active low |
| sclk_in | input | 1 | Serial clock pin, asynchronous |
| ctl_q | output | 4 | Control bits read back |
| fault_flag | output | 1 | Mode-fault flag |
| tx_empty | output | 1 | Transmit-empty flag |
| bit_cnt | output | 4 | Bit state counter |
| irq | output | 1 | Error interrupt request level |
| miso_oe | output | 1 | Output enable for the slave data-out pin |

## Verification
A change on a pin input reaches the flag, counter and control outputs on the third rising edge: two edges in the synchronizer, then the registered update. `miso_oe` changes one edge earlier. Writes and clear pulses take effect on the first rising edge. The bench drives pins on falling edges, waits four full cycles after each pin change and one cycle after each write, and then reads the outputs on a falling edge. It sweeps both clock polarities, both phases and deselect points after 0 to 8 clock pulses, and computes the expected flag and count from the phase and the number of pulses.

// File: rtl/spi_modf_guard.sv
module spi_modf_guard #(
  parameter int XFER_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       ctl_we,
  input  logic [3:0] ctl_din,
  input  logic       sts_clr,
  input  logic       tx_wr,
  input  logic       ss_n_in,
  input  logic       sclk_in,
  output logic [3:0] ctl_q,
  output logic       fault_flag,
  output logic       tx_empty,
  output logic [3:0] bit_cnt,
  output logic       irq,
  output logic       miso_oe
);
  localparam int CW = 4;
  localparam logic [CW-1:0] LAST = CW'(XFER_BITS - 1);
  localparam logic [CW-1:0] FULL = CW'(XFER_BITS);

  logic [1:0] ss_sy, ck_sy;
  logic       ss_d, ck_d, active;
  logic       en, mst, fe, ie;
  logic [CW-1:0] cnt;

  wire ss_s = ss_sy[1];
  wire ck_s = ck_sy[1];
  wire lead = (ck_s != cpol) && (ck_d == cpol);
  wire trail = (ck_s == cpol) && (ck_d != cpol);
  wire samp = cpha ? trail : lead;
  wire slv = en & ~mst;
  wire ss_fall = ~ss_s & ss_d;

  wire start = slv & ~ss_s & ~active & (cpha ? lead : (ss_fall | lead));
  wire cnt_go = en & (mst | (active & ~ss_s));
  wire endx = cnt_go & trail & (cpha ? (cnt == LAST) : (cnt == FULL));

  wire mfault = en & mst & fe & ~ss_s;
  wire sfault = slv & fe & active & ss_s;
  wire wr_off = ctl_we & ~ctl_din[0];
  wire wr_kill = ctl_we & (~ctl_din[0] | ~ctl_din[2]);
  wire clr_ok = sts_clr & (~mst | ss_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_sy <= 2'b11;
      ck_sy <= 2'b00;
      ss_d  <= 1'b1;
      ck_d  <= 1'b0;
    end else begin
      ss_sy <= {ss_sy[0], ss_n_in};
      ck_sy <= {ck_sy[0], sclk_in};
      ss_d  <= ss_s;
      ck_d  <= ck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      mst <= 1'b0;
      fe <= 1'b0;
      ie <= 1'b0;
    end else begin
      if (ctl_we) begin
        mst <= ctl_din[1];
        fe  <= ctl_din[2];
        ie  <= ctl_din[3];
      end
      if (mfault) en <= 1'b0;
      else if (ctl_we) en <= ctl_din[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_flag <= 1'b0;
    else if (mfault | sfault) fault_flag <= 1'b1;
    else if (wr_kill | clr_ok) fault_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_empty <= 1'b1;
    else if (mfault) tx_empty <= 1'b1;
    else if (tx_wr) tx_empty <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else if (wr_off | mfault | ~slv | ss_s) active <= 1'b0;
    else if (start) active <= 1'b1;
    else if (endx) active <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (wr_off | mfault) cnt <= '0;
    else if (start) cnt <= (!cpha && !ss_fall) ? CW'(1) : '0;
    else if (endx) cnt <= '0;
    else if (cnt_go && samp && cnt != FULL) cnt <= cnt + CW'(1);
  end

  assign ctl_q = {ie, fe, mst, en};
  assign bit_cnt = cnt;
  assign irq = fault_flag & ie;
  assign miso_oe = slv & ~ss_s;

  // R3
  mst_fault_fx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_flag) && mst && !$past(ctl_we)) |-> (!en && tx_empty && cnt == '0));

  // R8
  slv_fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_flag) && !mst && !$past(ctl_we)) |-> (en && $stable(cnt)));

  // R10
  mst_clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst && fault_flag && !ss_s && !ctl_we) |=> fault_flag);

  // R9
  ss_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mst && ss_s && !ctl_we) |=> $stable(cnt));

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  // R9
  oe_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (!mst && en && !ss_s));
endmodule

// File: tb/tb_spi_modf_guard.sv
module tb_spi_modf_guard;
  logic clk = 0, rst_n = 0, cpol = 0, cpha = 0, ctl_we = 0, sts_clr = 0, tx_wr = 0;
  logic ss_n_in = 1, sclk_in = 0;
  logic [3:0] ctl_din = 0;
  logic [3:0] ctl_q, bit_cnt;
  logic fault_flag, tx_empty, irq, miso_oe;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_modf_guard dut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .ctl_we(ctl_we),
    .ctl_din(ctl_din), .sts_clr(sts_clr), .tx_wr(tx_wr), .ss_n_in(ss_n_in),
    .sclk_in(sclk_in), .ctl_q(ctl_q), .fault_flag(fault_flag), .tx_empty(tx_empty),
    .bit_cnt(bit_cnt), .irq(irq), .miso_oe(miso_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_ctl(input bit e, input bit m, input bit f, input bit i);
    @(negedge clk);
    ctl_din = {i, f, m, e};
    ctl_we = 1;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic clr();
    @(negedge clk);
    sts_clr = 1;
    @(negedge clk);
    sts_clr = 0;
  endtask

  task automatic pulses(input int n);
    for (int p = 0; p < n; p++) begin
      sclk_in = ~cpol;
      settle();
      sclk_in = cpol;
      settle();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit expf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ctl", ctl_q, 0);
    chk("R1 flag", fault_flag, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 cnt", bit_cnt, 0);
    chk("R1 irq", irq, 0);
    chk("R1 oe", miso_oe, 0);

    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
        for (int k = 0; k <= 8; k++) begin
          ss_n_in = 1;
          cpol = pol[0];
          cpha = pha[0];
          sclk_in = pol[0];
          settle();
          wr_ctl(1, 0, 1, k[0]);
          clr();
          chk("R10 slave clear", fault_flag, 0);
          ss_n_in = 0;
          settle();
          chk("R9 oe on select", miso_oe, 1);
          pulses(k);
          chk("R7 count", bit_cnt, (k == 8) ? 0 : k);
          ss_n_in = 1;
          settle();
          expf = (k != 8) && (pha == 0 || k > 0);
          if (pha == 0) chk("R5 phase0 flag", fault_flag, expf);
          else chk("R6 phase1 flag", fault_flag, expf);
          chk("R8 enable kept", ctl_q[0], 1);
          chk("R8 count kept", bit_cnt, (k == 8) ? 0 : k);
          chk("R4 irq", irq, expf & k[0]);
          chk("R9 oe off", miso_oe, 0);
          pulses(2);
          chk("R9 clocks ignored", bit_cnt, (k == 8) ? 0 : k);
          clr();
          chk("R10 slave clear after", fault_flag, 0);
        end

    cpol = 0;
    sclk_in = 0;
    for (int ie = 0; ie < 2; ie++)
      for (int pha = 0; pha < 2; pha++) begin
        cpha = pha[0];
        ss_n_in = 1;
        settle();
        wr_ctl(1, 1, 1, ie[0]);
        clr();
        @(negedge clk);
        tx_wr = 1;
        @(negedge clk);
        tx_wr = 0;
        chk("R12 tx_empty cleared", tx_empty, 0);
        pulses(3);
        chk("R7 master count", bit_cnt, 3);
        ss_n_in = 0;
        settle();
        chk("R2 master flag", fault_flag, 1);
        chk("R3 enable off", ctl_q[0], 0);
        chk("R3 master kept", ctl_q[1], 1);
        chk("R3 tx_empty set", tx_empty, 1);
        chk("R3 cnt cleared", bit_cnt, 0);
        chk("R4 master irq", irq, ie);
        clr();
        chk("R10 clear blocked", fault_flag, 1);
        ss_n_in = 1;
        settle();
        chk("R10 held until clear", fault_flag, 1);
        clr();
        chk("R10 clear ok", fault_flag, 0);
        chk("R4 irq low", irq, 0);
      end

    wr_ctl(1, 1, 0, 1);
    ss_n_in = 0;
    settle();
    chk("R2 no fault without enable", fault_flag, 0);
    chk("R2 enable kept", ctl_q[0], 1);
    ss_n_in = 1;
    settle();
    wr_ctl(1, 1, 1, 1);
    ss_n_in = 0;
    settle();
    chk("R11 master fault set", fault_flag, 1);
    wr_ctl(0, 1, 0, 1);
    chk("R11 fault enable off clears", fault_flag, 0);
    ss_n_in = 1;
    settle();

    cpha = 0;
    wr_ctl(1, 0, 1, 1);
    ss_n_in = 0;
    settle();
    pulses(2);
    ss_n_in = 1;
    settle();
    chk("R5 slave fault", fault_flag, 1);
    chk("R8 cnt after fault", bit_cnt, 2);
    wr_ctl(0, 0, 1, 1);
    chk("R11 enable off clears flag", fault_flag, 0);
    chk("R11 enable off clears cnt", bit_cnt, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule